// File: doc/BRIEF.md
# Reset Auto-Jump Sequencer

This block makes a processor begin execution at a strap-chosen address after every restart, no matter what memory holds at the reset vector. It injects a complete three-byte unconditional jump instruction onto the instruction byte path. The processor then fetches the jump and continues from the strapped target.

A four-state sequencer holds the position in the injection. The restart condition returns it to its first state. It moves forward by one state at the end of each processor read cycle, so every injected byte stays unchanged for the whole read that fetches it. The control half turns the state into a few select strobes. The datapath half uses them to pick the opcode, the low address byte or the high address byte. After the third byte has been read, the sequencer parks in a done state. There it drives zero, stays inactive and ignores reads until the next restart.

Top module: `reset_jump_seq`

## Requirements
- R1: While `restart` is high at a rising clock edge, the sequencer returns to its first state. From the cycle after that edge, `instrByte` is 0xC3, `jumpActive` is 1 and `jumpDone` is 0.
- R2: The sequencer advances exactly one state at the first rising edge where `rdStrobe` is sampled low after being sampled high at the previous edge. While `rdStrobe` stays high, however long, the state and `instrByte` do not change.
- R3: In the first state, `instrByte` carries the unconditional jump opcode 0xC3.
- R4: In the second state, `instrByte` carries bits 7:0 of `jumpAddr`.
- R5: In the third state, `instrByte` carries bits 15:8 of `jumpAddr`.
- R6: After the read in the third state ends, the sequencer is in the done state. There `jumpDone` is 1, `jumpActive` is 0 and `instrByte` is 0x00.
- R7: In the done state, further read cycles and changes to `jumpAddr` have no effect on the three outputs until a restart.
- R8: A restart wins over a read trailing edge that falls in the same cycle. A restart in the middle of the sequence, or after it has finished, starts the injection again from the opcode byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| restart | input | 1 | Synchronous restart / power-on condition, active high |
| rdStrobe | input | 1 | High for the duration of each processor read cycle |
| jumpAddr | input | 16 | Strapped jump target address |
| instrByte | output | 8 | Injected instruction byte, 0 when idle |
| jumpActive | output | 1 | High while the jump is being injected |
| jumpDone | output | 1 | High once the injection has finished |

## Verification
The two functions that can meet in one cycle are the restart and the trailing edge of a read strobe. The bench provokes this by ending a read in the second or third state and raising `restart` at that same clock edge. The outcome is judged correct only if the outputs come back as the opcode byte with active set, rather than the next address byte. A second case applies the restart while the strobe is still high, then lets that read end afterwards. That read must advance the sequencer from its first state to the low address byte.

// File: rtl/autojmp_pkg.sv
package autojmp_pkg;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } ajState_e;

  // strobes from control to datapath, at most one set at a time
  typedef struct packed {
    logic opSel;
    logic loSel;
    logic hiSel;
    logic done;
  } ajStrobes_t;

endpackage

// File: rtl/autojmp_ctrl.sv
module autojmp_ctrl
  import autojmp_pkg::*;
(
  input  logic       clk,
  input  logic       restart,
  input  logic       rdStrobe,
  output ajStrobes_t strb
);

  ajState_e stateQ, stateD;
  logic     rdPrevQ;
  logic     rdTrail;

  assign rdTrail = rdPrevQ & ~rdStrobe;

  always_comb begin
    stateD = stateQ;
    if (rdTrail) begin
      unique case (stateQ)
        ST_OPC:  stateD = ST_LO;
        ST_LO:   stateD = ST_HI;
        ST_HI:   stateD = ST_DONE;
        default: stateD = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      stateQ  <= ST_OPC;
      rdPrevQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      rdPrevQ <= rdStrobe;
    end
  end

  always_comb begin
    strb = '0;
    unique case (stateQ)
      ST_OPC:  strb.opSel = 1'b1;
      ST_LO:   strb.loSel = 1'b1;
      ST_HI:   strb.hiSel = 1'b1;
      default: strb.done  = 1'b1;
    endcase
  end

endmodule

// File: rtl/autojmp_datapath.sv
module autojmp_datapath
  import autojmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [BYTE_W-1:0] JMP_OPC = 8'hC3
) (
  input  ajStrobes_t        strb,
  input  logic [ADDR_W-1:0] jumpAddr,
  output logic [BYTE_W-1:0] instrByte,
  output logic              jumpActive,
  output logic              jumpDone
);

  localparam int unsigned NBYTES = ADDR_W / BYTE_W;

  logic [BYTE_W-1:0] addrByte [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_slice
    assign addrByte[g] = jumpAddr[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    instrByte = '0;
    if (strb.opSel)      instrByte = JMP_OPC;
    else if (strb.loSel) instrByte = addrByte[0];
    else if (strb.hiSel) instrByte = addrByte[NBYTES-1];
  end

  assign jumpActive = strb.opSel | strb.loSel | strb.hiSel;
  assign jumpDone   = strb.done;

endmodule

// File: rtl/reset_jump_seq.sv
module reset_jump_seq
  import autojmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [BYTE_W-1:0] JMP_OPC = 8'hC3
) (
  input  logic              clk,
  input  logic              restart,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] jumpAddr,
  output logic [BYTE_W-1:0] instrByte,
  output logic              jumpActive,
  output logic              jumpDone
);

  ajStrobes_t strb;

  autojmp_ctrl u_ctrl (
    .clk      (clk),
    .restart  (restart),
    .rdStrobe (rdStrobe),
    .strb     (strb)
  );

  autojmp_datapath #(
    .BYTE_W  (BYTE_W),
    .ADDR_W  (ADDR_W),
    .JMP_OPC (JMP_OPC)
  ) u_dp (
    .strb       (strb),
    .jumpAddr   (jumpAddr),
    .instrByte  (instrByte),
    .jumpActive (jumpActive),
    .jumpDone   (jumpDone)
  );

endmodule

// File: rtl/reset_jump_seq_chk.sv
module reset_jump_seq_chk
  import autojmp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] JMP_OPC = 8'hC3
) (
  input logic              clk,
  input logic              restart,
  input logic              rdStrobe,
  input ajStrobes_t        strb,
  input logic [BYTE_W-1:0] instrByte,
  input logic              jumpActive,
  input logic              jumpDone
);

  logic rdSeen;
  always_ff @(posedge clk) begin
    if (restart) rdSeen <= 1'b0;
    else         rdSeen <= rdStrobe;
  end

  // R1: first cycle out of restart shows the opcode
  p_restart_opc_r1: assert property (@(posedge clk) disable iff (restart)
    $fell(restart) |-> (instrByte == JMP_OPC && jumpActive && !jumpDone));

  // R2: no movement while the read strobe is held
  p_hold_in_read_r2: assert property (@(posedge clk) disable iff (restart)
    rdStrobe |=> $stable(strb));

  // R2: trailing edge in the opcode state moves to the low byte
  p_step_op_lo_r2: assert property (@(posedge clk) disable iff (restart)
    (rdSeen && !rdStrobe && strb.opSel) |=> strb.loSel);

  // R3: strobes one-hot
  p_one_sel_r3: assert property (@(posedge clk) disable iff (restart)
    $countones(strb) == 1);

  // R6: done state is quiet
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (restart)
    jumpDone |-> (instrByte == '0 && !jumpActive));

  // R7: done is sticky until restart
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (restart)
    jumpDone |=> jumpDone);

endmodule

bind reset_jump_seq reset_jump_seq_chk #(
  .BYTE_W  (BYTE_W),
  .JMP_OPC (JMP_OPC)
) u_chk (
  .clk        (clk),
  .restart    (restart),
  .rdStrobe   (rdStrobe),
  .strb       (strb),
  .instrByte  (instrByte),
  .jumpActive (jumpActive),
  .jumpDone   (jumpDone)
);

// File: tb/tb_reset_jump_seq.sv
`timescale 1ns/1ps
module tb_reset_jump_seq;

  typedef struct {
    logic [7:0] byteV;
    logic       act;
    logic       dn;
    string      tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        restart = 1'b1;
  logic        rdStrobe = 1'b0;
  logic [15:0] jumpAddr = 16'h1234;
  logic [7:0]  instrByte;
  logic        jumpActive;
  logic        jumpDone;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  expItem_t expQ[$];

  // bench reference: stage 0..3 and last sampled strobe
  int   mStage = 0;
  logic mPrev = 1'b0;

  always #10 clk = ~clk;

  reset_jump_seq dut (
    .clk        (clk),
    .restart    (restart),
    .rdStrobe   (rdStrobe),
    .jumpAddr   (jumpAddr),
    .instrByte  (instrByte),
    .jumpActive (jumpActive),
    .jumpDone   (jumpDone)
  );

  // driver: apply inputs at a falling edge, queue the outputs expected after the next rising edge
  task automatic step(input logic r, input logic rd, input logic [15:0] addr, input string tag);
    expItem_t e;
    @(negedge clk);
    restart  = r;
    rdStrobe = rd;
    jumpAddr = addr;
    if (r) begin
      mStage = 0;
      mPrev  = 1'b0;
    end else begin
      if (mPrev && !rd && mStage < 3) mStage++;
      mPrev = rd;
    end
    case (mStage)
      0: e.byteV = 8'hC3;
      1: e.byteV = addr[7:0];
      2: e.byteV = addr[15:8];
      default: e.byteV = 8'h00;
    endcase
    e.act = (mStage < 3);
    e.dn  = (mStage == 3);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (instrByte !== e.byteV || jumpActive !== e.act || jumpDone !== e.dn) begin
          fails++;
          $display("FAIL %s: got byte=%h act=%b done=%b expected byte=%h act=%b done=%b",
                   e.tag, instrByte, jumpActive, jumpDone, e.byteV, e.act, e.dn);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1, 0, 16'h1234, "R1");
    step(1, 0, 16'h1234, "R1");
    step(0, 0, 16'h1234, "R1");
    // R2 / R3: long read holds opcode
    step(0, 1, 16'h1234, "R3");
    step(0, 1, 16'h1234, "R2");
    step(0, 1, 16'h1234, "R2");
    step(0, 0, 16'h1234, "R4");
    step(0, 0, 16'h1234, "R4");
    // R5: one-cycle read
    step(0, 1, 16'h1234, "R4");
    step(0, 0, 16'h1234, "R5");
    step(0, 1, 16'h1234, "R5");
    step(0, 0, 16'h1234, "R6");
    // R7: reads and strap changes in done
    step(0, 1, 16'hBEEF, "R7");
    step(0, 0, 16'hBEEF, "R7");
    step(0, 1, 16'hA5A5, "R7");
    step(0, 0, 16'hA5A5, "R7");
    // R8: restart after done, new strap, back-to-back reads
    step(1, 0, 16'hBEEF, "R8");
    step(0, 1, 16'hBEEF, "R8");
    step(0, 0, 16'hBEEF, "R4");
    step(0, 1, 16'hBEEF, "R4");
    // R8: restart coincides with trailing edge in the high-byte step
    step(1, 0, 16'hBEEF, "R8");
    step(0, 1, 16'hBEEF, "R8");
    step(0, 0, 16'hBEEF, "R4");
    step(0, 1, 16'hBEEF, "R4");
    step(0, 0, 16'hBEEF, "R5");
    step(0, 1, 16'hBEEF, "R5");
    step(1, 0, 16'hBEEF, "R8");
    step(0, 0, 16'hBEEF, "R8");
    // R2: restart while strobe high, read ends afterwards
    step(0, 1, 16'h00FF, "R2");
    step(1, 1, 16'h00FF, "R8");
    step(0, 1, 16'h00FF, "R2");
    step(0, 0, 16'h00FF, "R2");
    step(0, 1, 16'h00FF, "R5");
    step(0, 0, 16'h00FF, "R5");
    step(0, 1, 16'h00FF, "R6");
    step(0, 0, 16'h00FF, "R6");
    step(0, 0, 16'h00FF, "R7");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule